// File: doc/BRIEF.md
# Configurable Registered/Combinational Output Cell Bank

This block is a row of output cells for a programmable sum-of-products logic array. Each cell takes the OR sum computed for it by the array and a per-cell output-enable term. It drives a tristate pin model, made of a data bit, an enable bit and a high-impedance flag. It also returns a feedback bit to the array. Two configuration bits per cell choose how the cell behaves. One bit selects whether the pin follows a D flip-flop or the raw sum. The other bit selects whether the pin carries that value as is (active-high) or inverted (active-low).

All cells share one clock, one synchronous preset term and one asynchronous clear term. A true preset loads every flip-flop with HIGH at the next rising clock edge. A true clear forces every flip-flop LOW at once and holds it there, with no clock needed. When both terms are true, the clear wins. A separate active-low power-on reset also clears the flip-flops.

In registered mode the feedback returns the flip-flop state. In combinational mode the feedback returns whatever is on the pin. While the cell drives the pin, that is the cell's own output. While the pin is released, it is the externally applied level, so a released pin works as a plain input to the array.

Top module: `outcell_bank`

## Requirements
- R1: While `rst_n` is low, every cell's flip-flop is LOW; a registered active-high cell then drives data 0 and a registered active-low cell drives data 1.
- R2: A cell with `cfg_reg_i` bit = 1 (registered) loads its sum into its flip-flop on the rising clock edge; between edges a change of the sum leaves its pin data and feedback unchanged.
- R3: A cell with `cfg_reg_i` bit = 0 (combinational) passes its sum to the pin data without waiting for a clock edge.
- R4: A cell with `cfg_inv_i` bit = 1 drives the complement of its selected value (flip-flop or sum) on pin data; with the bit at 0 it drives the value unchanged.
- R5: When `preset_term_i` is 1 and `clear_term_i` is 0 at a rising clock edge, every flip-flop becomes HIGH whatever the sums are.
- R6: When `clear_term_i` becomes 1, every flip-flop becomes LOW without a clock edge and stays LOW through clock edges while the term stays 1.
- R7: When `preset_term_i` and `clear_term_i` are both 1 at a rising edge, the flip-flops are LOW.
- R8: `pin_en_o` bit equals the cell's `oe_term_i` bit, and `pin_hiz_o` bit is its complement.
- R9: A registered cell's feedback equals its flip-flop state at true polarity, whatever its polarity bit and output enable are.
- R10: A combinational cell's feedback equals its pin data while enabled, and equals its `pin_in_i` bit while released.
- R11: The preset and clear terms have no effect on the pin data or feedback of a combinational cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock; flip-flops load on the rising edge |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| sum_i | input | NUM_CELLS | Sum-of-products value for each cell |
| oe_term_i | input | NUM_CELLS | Output-enable term for each cell, 1 = drive pin |
| preset_term_i | input | 1 | Global synchronous preset term, 1 = set flip-flops HIGH |
| clear_term_i | input | 1 | Global asynchronous clear term, 1 = force flip-flops LOW |
| cfg_reg_i | input | NUM_CELLS | Per-cell mode bit, 1 = registered, 0 = combinational |
| cfg_inv_i | input | NUM_CELLS | Per-cell polarity bit, 1 = active-low, 0 = active-high |
| pin_in_i | input | NUM_CELLS | Level seen on each pin when the cell releases it |
| pin_data_o | output | NUM_CELLS | Data value offered to each pin |
| pin_en_o | output | NUM_CELLS | Pin driver enable per cell |
| pin_hiz_o | output | NUM_CELLS | High-impedance indication per cell |
| fb_o | output | NUM_CELLS | Feedback returned to the array per cell |

## Verification
The bench builds the bank with NUM_CELLS = 4 and puts each cell in a different one of the four configurations: registered active-high, registered active-low, combinational active-high and combinational active-low. Each preset, clear and sum pattern therefore exercises every configuration in the same cycle under the shared global terms. This shows directly that combinational cells ignore preset and clear while registered cells obey them, and that polarity acts after the registered/combinational selection. The default of ten cells only adds copies of the same cell, so the smaller build reaches the same behaviour.

// File: rtl/outcell_pkg.sv
package outcell_pkg;

    // Per-cell configuration: two independent selection bits
    typedef struct packed {
        logic registered;   // 1: pin follows flip-flop, 0: pin follows sum
        logic active_low;   // 1: complement the selected value on the pin
    } cell_cfg_t;

    // Everything one cell presents at its pin and back to the array
    typedef struct packed {
        logic data;
        logic en;
        logic hiz;
        logic fb;
    } cell_pins_t;

endpackage

// File: rtl/outcell_reg.sv
// Flip-flop row shared by all cells: synchronous preset, asynchronous clear.
module outcell_reg #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             preset_i,
    input  logic             clear_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] q;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       async_clr;

    // Power-on reset and the clear term both force LOW without a clock;
    // because they act asynchronously, clear dominates a concurrent preset.
    assign async_clr = ~rst_n | clear_i;

    always_comb begin
        st_d = st_q;
        if (preset_i) begin
            st_d.q = '1;
        end else begin
            st_d.q = sum_i;
        end
    end

    always_ff @(posedge clk or posedge async_clr) begin
        if (async_clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;

endmodule

// File: rtl/outcell_drive.sv
// Output selection, polarity, tristate model and feedback for one cell.
module outcell_drive
    import outcell_pkg::*;
(
    input  cell_cfg_t  cfg_i,
    input  logic       sum_i,
    input  logic       q_i,
    input  logic       oe_i,
    input  logic       pin_in_i,
    output cell_pins_t pins_o
);

    logic selected;
    logic driven;

    always_comb begin
        selected    = cfg_i.registered ? q_i : sum_i;
        driven      = selected ^ cfg_i.active_low;
        pins_o.data = driven;
        pins_o.en   = oe_i;
        pins_o.hiz  = ~oe_i;
        if (cfg_i.registered) begin
            pins_o.fb = q_i;
        end else begin
            // pin level: own output while driven, external level otherwise
            pins_o.fb = oe_i ? driven : pin_in_i;
        end
    end

endmodule

// File: rtl/outcell_bank.sv
// Bank of output cells sharing clock, preset and clear.
module outcell_bank
    import outcell_pkg::*;
#(
    parameter int NUM_CELLS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CELLS-1:0] sum_i,
    input  logic [NUM_CELLS-1:0] oe_term_i,
    input  logic                 preset_term_i,
    input  logic                 clear_term_i,
    input  logic [NUM_CELLS-1:0] cfg_reg_i,
    input  logic [NUM_CELLS-1:0] cfg_inv_i,
    input  logic [NUM_CELLS-1:0] pin_in_i,
    output logic [NUM_CELLS-1:0] pin_data_o,
    output logic [NUM_CELLS-1:0] pin_en_o,
    output logic [NUM_CELLS-1:0] pin_hiz_o,
    output logic [NUM_CELLS-1:0] fb_o
);

    localparam int LAST_CELL = NUM_CELLS - 1;

    logic [LAST_CELL:0] q_row;

    outcell_reg #(
        .WIDTH(NUM_CELLS)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sum_i   (sum_i),
        .preset_i(preset_term_i),
        .clear_i (clear_term_i),
        .q_o     (q_row)
    );

    for (genvar c = 0; c <= LAST_CELL; c++) begin : g_cell
        cell_cfg_t  cfg;
        cell_pins_t pins;

        assign cfg.registered = cfg_reg_i[c];
        assign cfg.active_low = cfg_inv_i[c];

        outcell_drive u_drive (
            .cfg_i   (cfg),
            .sum_i   (sum_i[c]),
            .q_i     (q_row[c]),
            .oe_i    (oe_term_i[c]),
            .pin_in_i(pin_in_i[c]),
            .pins_o  (pins)
        );

        assign pin_data_o[c] = pins.data;
        assign pin_en_o[c]   = pins.en;
        assign pin_hiz_o[c]  = pins.hiz;
        assign fb_o[c]       = pins.fb;
    end

endmodule

// File: rtl/outcell_bank_chk.sv
module outcell_bank_chk #(
    parameter int NUM_CELLS = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CELLS-1:0] sum_i,
    input logic [NUM_CELLS-1:0] oe_term_i,
    input logic                 preset_term_i,
    input logic                 clear_term_i,
    input logic [NUM_CELLS-1:0] cfg_reg_i,
    input logic [NUM_CELLS-1:0] cfg_inv_i,
    input logic [NUM_CELLS-1:0] pin_in_i,
    input logic [NUM_CELLS-1:0] pin_data_o,
    input logic [NUM_CELLS-1:0] pin_en_o,
    input logic [NUM_CELLS-1:0] pin_hiz_o,
    input logic [NUM_CELLS-1:0] fb_o
);

    // Registered cells load the previous sum when no global term interfered
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(preset_term_i) && !$past(clear_term_i)
         && !clear_term_i && $stable(cfg_reg_i))
        |-> ((fb_o & cfg_reg_i) == ($past(sum_i) & cfg_reg_i)));

    // Combinational cells: pin data is the sum under the polarity bit
    assert_comb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_data_o ^ cfg_inv_i) & ~cfg_reg_i) == (sum_i & ~cfg_reg_i)));

    // Preset loads HIGH into every registered cell
    assert_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(preset_term_i) && !$past(clear_term_i)
         && !clear_term_i && $stable(cfg_reg_i))
        |-> ((fb_o & cfg_reg_i) == cfg_reg_i));

    // Clear holds registered cells LOW, also against a concurrent preset (R7)
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_term_i |-> ((fb_o & cfg_reg_i) == '0));

    // Pin enable and high-impedance flag follow the enable term
    assert_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_en_o == oe_term_i) && (pin_hiz_o == ~oe_term_i)));

    // Combinational feedback mirrors the pin level
    assert_feedback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((fb_o & ~cfg_reg_i) ==
         (((oe_term_i & pin_data_o) | (~oe_term_i & pin_in_i)) & ~cfg_reg_i)));

endmodule

bind outcell_bank outcell_bank_chk #(
    .NUM_CELLS(NUM_CELLS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sum_i        (sum_i),
    .oe_term_i    (oe_term_i),
    .preset_term_i(preset_term_i),
    .clear_term_i (clear_term_i),
    .cfg_reg_i    (cfg_reg_i),
    .cfg_inv_i    (cfg_inv_i),
    .pin_in_i     (pin_in_i),
    .pin_data_o   (pin_data_o),
    .pin_en_o     (pin_en_o),
    .pin_hiz_o    (pin_hiz_o),
    .fb_o         (fb_o)
);

// File: tb/outcell_bank_tb.sv
module outcell_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int WATCHDOG   = 200000;

    // cell 0: reg/high, 1: reg/low, 2: comb/high, 3: comb/low
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] sum = '0;
    logic [N-1:0] oe = '1;
    logic         preset = 1'b0;
    logic         clear = 1'b0;
    logic [N-1:0] cfg_reg = 4'b0011;
    logic [N-1:0] cfg_inv = 4'b1010;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_data, pin_en, pin_hiz, fb;

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] exp_q = 2'b00;

    outcell_bank #(.NUM_CELLS(N)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sum_i        (sum),
        .oe_term_i    (oe),
        .preset_term_i(preset),
        .clear_term_i (clear),
        .cfg_reg_i    (cfg_reg),
        .cfg_inv_i    (cfg_inv),
        .pin_in_i     (pin_in),
        .pin_data_o   (pin_data),
        .pin_en_o     (pin_en),
        .pin_hiz_o    (pin_hiz),
        .fb_o         (fb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // registered cells against the bench's flip-flop model
    task automatic chk_reg_cells(input string req);
        chk(req, {30'd0, fb[1:0]}, {30'd0, exp_q});
        chk(req, {30'd0, pin_data[1:0]}, {30'd0, ~exp_q[1], exp_q[0]});
    endtask

    // combinational cells with enabled pins
    task automatic chk_comb_cells(input string req);
        chk(req, {30'd0, pin_data[3:2]}, {30'd0, ~sum[3], sum[2]});
        chk(req, {30'd0, fb[3:2]}, {30'd0, ~sum[3], sum[2]});
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        exp_q = 2'b00;
        chk_reg_cells("R1 power-on reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk_reg_cells("R1 after release, sum zero");
    endtask

    task automatic t_capture();
        logic [N-1:0] pats [4] = '{4'b0011, 4'b0001, 4'b0010, 4'b0000};
        foreach (pats[i]) begin
            @(negedge clk); sum = pats[i]; #1;
            chk_reg_cells("R2 hold between edges");
            @(posedge clk); #1;
            exp_q = sum[1:0];
            chk_reg_cells("R2 R4 R9 capture on edge");
        end
    endtask

    task automatic t_comb();
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); sum = {v[1:0], exp_q}; #1;
            chk_comb_cells("R3 R4 combinational pass");
        end
    endtask

    task automatic t_preset();
        @(negedge clk); sum = 4'b0100; preset = 1'b1;
        @(posedge clk); #1;
        exp_q = 2'b11;
        chk_reg_cells("R5 preset sets HIGH");
        chk_comb_cells("R11 comb ignores preset");
        @(negedge clk); preset = 1'b0; sum = 4'b0000;
        @(posedge clk); #1;
        exp_q = 2'b00;
        chk_reg_cells("R2 capture after preset");
    endtask

    task automatic t_clear();
        @(negedge clk); sum = 4'b1111;
        @(posedge clk); #1;
        exp_q = 2'b11;
        chk_reg_cells("R2 load ones");
        @(negedge clk); #2; clear = 1'b1; #1;
        exp_q = 2'b00;
        chk_reg_cells("R6 clear without edge");
        chk_comb_cells("R11 comb ignores clear");
        @(posedge clk); #1;
        chk_reg_cells("R6 clear held through edge");
        @(negedge clk); clear = 1'b0;
        @(posedge clk); #1;
        exp_q = 2'b11;
        chk_reg_cells("R2 capture resumes after clear");
    endtask

    task automatic t_both();
        @(negedge clk); sum = 4'b0000; preset = 1'b1; clear = 1'b1;
        @(posedge clk); #1;
        exp_q = 2'b00;
        chk_reg_cells("R7 clear beats preset");
        @(negedge clk); preset = 1'b0; clear = 1'b0;
        @(posedge clk); #1;
        chk_reg_cells("R7 after release");
    endtask

    task automatic t_oe();
        @(negedge clk); sum = 4'b0011;
        @(posedge clk); #1;
        exp_q = 2'b11;
        @(negedge clk); oe = 4'b0000; pin_in = 4'b1000; #1;
        chk("R8 enable off", {28'd0, pin_en}, 32'h0);
        chk("R8 hiz on", {28'd0, pin_hiz}, 32'hf);
        chk("R9 reg feedback with pins released", {30'd0, fb[1:0]}, 32'h3);
        chk("R10 released comb feedback", {30'd0, fb[3:2]}, 32'h2);
        pin_in = 4'b0100; #1;
        chk("R10 released comb feedback follows pin", {30'd0, fb[3:2]}, 32'h1);
        oe = 4'b0101; #1;
        chk("R8 mixed enable", {28'd0, pin_en}, 32'h5);
        chk("R8 mixed hiz", {28'd0, pin_hiz}, 32'ha);
        // cell 2 enabled: drives sum 0; cell 3 released: pin_in bit 3 = 0
        chk("R10 mixed comb feedback", {30'd0, fb[3:2]}, 32'h0);
        @(negedge clk); oe = 4'b1111; pin_in = 4'b0000;
    endtask

    task automatic t_reset_midrun();
        @(negedge clk); rst_n = 1'b0; #1;
        exp_q = 2'b00;
        chk_reg_cells("R1 reset mid-run");
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_capture();
        t_comb();
        t_preset();
        t_clear();
        t_both();
        t_oe();
        t_reset_midrun();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule